// File: doc/BRIEF.md
# Runtime-Writable Lookup Logic Cell

This block is one fine-grain cell of an embedded programmable fabric. It holds two four-input function tables, called F and G, and a three-input table, H, that merges the F and G results with one extra input. Two carry stages give fast arithmetic. Two storage flops sit behind the cell outputs, and each flop can be bypassed. A small static mode word selects how these pieces connect. That word holds the H table, the output selects, the bypass bits, the clock-enable use, the set/reset load values and the carry enable. How the mode word gets loaded is outside the block.

The F and G tables are 16x1 memories. They are rewritten at run time through a narrow port: one data bit, a write strobe and a four-bit entry address. A mode bit decides which of the two tables a write goes to. Reloading a whole table therefore takes sixteen cycles.

A table read is combinational, so the value written at a clock edge appears on the outputs in the next cycle. Any flop that captures at that same edge still sees the previous contents.

Top module: `lut_logic_cell`

## Requirements
- R1: With `cfg_we` high at a rising edge, `cfg_din` is stored in entry `cfg_addr` of table F when mode bit `tbl_sel` is 0, or of table G when it is 1. The other table and all other entries keep their values. With `cfg_we` low, neither table changes.
- R2: Output F' equals entry `f_in` of table F, with `f_in[3]` as the most significant index bit. G' equals entry `g_in` of table G in the same way.
- R3: H' equals bit `{h_in, G', F'}` of the mode field `h_tab`: `h_in` is index bit 2, G' is bit 1 and F' is bit 0.
- R4: `x_o` is H' when mode bit `x_sel` is 1 and F' otherwise. `y_o` is H' when `y_sel` is 1 and G' otherwise.
- R5: When `carry_en` is 1, `cin` replaces F index bit 2. A mid carry, the majority of `f_in[0]`, `f_in[1]` and `cin`, replaces G index bit 2. `cout` is the majority of `g_in[0]`, `g_in[1]` and the mid carry. When `carry_en` is 0, the indices are the raw inputs and `cout` is 0.
- R6: When `sr` is low, each flop loads its combinational output at a rising edge if `ce_use` is 0 or `ec` is 1. Otherwise it holds its value.
- R7: When `sr` is high at an edge, the X flop loads mode bit `srv_x` and the Y flop loads `srv_y`. This happens whatever the value of `ec`.
- R8: When `x_byp` is 1, `xq_o` equals `x_o`. When `x_byp` is 0, `xq_o` is the X flop. The same holds for `y_byp`, `yq_o` and the Y flop.
- R9: While `rst_n` is low, both tables and both flops are cleared to 0.
- R10: When a table entry is written at the same edge at which a flop captures a result that reads that entry, the flop takes the value from the old entry. The combinational output shows the new value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | MODE_W (17) | Static mode word (packed `lcell_mode_t`) |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 4 | Table entry address |
| cfg_din | input | 1 | Table write data bit |
| f_in | input | 4 | F table inputs |
| g_in | input | 4 | G table inputs |
| h_in | input | 1 | Extra H table input |
| cin | input | 1 | Carry in |
| ec | input | 1 | Flop clock enable |
| sr | input | 1 | Synchronous set/reset of both flops |
| x_o | output | 1 | Combinational X |
| y_o | output | 1 | Combinational Y |
| xq_o | output | 1 | Registered or bypassed X |
| yq_o | output | 1 | Registered or bypassed Y |
| cout | output | 1 | Carry out |

## Verification
A table write and a flop capture can land on the same clock edge, and they can involve the very entry that the flop's data path is reading. The bench provokes this by writing the complement of the entry currently indexed by `f_in` while the flop is enabled. The scoreboard model keeps the table contents both before and after the write. It expects the registered output to carry the old entry and the combinational output, sampled after the edge, to carry the new one. A second collision, set/reset against a low clock enable, is judged the same way: `sr` must win.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int LUT_K     = 4;
  localparam int LUT_D     = 1 << LUT_K;
  localparam int H_K       = 3;
  localparam int H_D       = 1 << H_K;
  localparam int CARRY_POS = 2;

  typedef struct packed {
    logic [H_D-1:0] h_tab;
    logic           tbl_sel;
    logic           x_sel;
    logic           y_sel;
    logic           x_byp;
    logic           y_byp;
    logic           ce_use;
    logic           srv_x;
    logic           srv_y;
    logic           carry_en;
  } lcell_mode_t;

  localparam int MODE_W = $bits(lcell_mode_t);

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/lcell_table.sv
module lcell_table #(
  parameter int K = 4,
  localparam int D = 1 << K
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [K-1:0] wr_addr,
  input  logic         wr_bit,
  input  logic [K-1:0] rd_idx,
  output logic         rd_bit,
  output logic [D-1:0] tab_o
);
  logic [D-1:0] tab_q, tab_d;

  always_comb begin
    tab_d = tab_q;
    if (wr_en) tab_d[wr_addr] = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tab_q <= '0;
    else        tab_q <= tab_d;
  end

  assign rd_bit = tab_q[rd_idx];
  assign tab_o  = tab_q;
endmodule

// File: rtl/lcell_carry.sv
module lcell_carry
  import lcell_pkg::*;
(
  input  logic       en,
  input  logic       cin,
  input  logic [1:0] fa,
  input  logic [1:0] ga,
  output logic       c_mid,
  output logic       cout
);
  assign c_mid = maj3(fa[0], fa[1], cin);
  assign cout  = en ? maj3(ga[0], ga[1], c_mid) : 1'b0;
endmodule

// File: rtl/lcell_store.sv
module lcell_store (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic ce,
  input  logic sr,
  input  logic sr_val,
  input  logic byp,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (sr)      q_d = sr_val;
    else if (ce) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = byp ? d : q_q;
endmodule

// File: rtl/lut_logic_cell.sv
module lut_logic_cell
  import lcell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_we,
  input  logic [LUT_K-1:0]  cfg_addr,
  input  logic              cfg_din,
  input  logic [LUT_K-1:0]  f_in,
  input  logic [LUT_K-1:0]  g_in,
  input  logic              h_in,
  input  logic              cin,
  input  logic              ec,
  input  logic              sr,
  output logic              x_o,
  output logic              y_o,
  output logic              xq_o,
  output logic              yq_o,
  output logic              cout
);
  lcell_mode_t md;
  assign md = lcell_mode_t'(cfg_mode);

  logic             c_mid;
  logic [LUT_K-1:0] lut_idx [2];
  logic [1:0]       lut_q;
  logic [LUT_D-1:0] tab_arr [2];
  logic [LUT_D-1:0] tab_f, tab_g;
  logic [H_K-1:0]   h_idx;
  logic             h_q;

  lcell_carry u_carry (
    .en    (md.carry_en),
    .cin   (cin),
    .fa    (f_in[1:0]),
    .ga    (g_in[1:0]),
    .c_mid (c_mid),
    .cout  (cout)
  );

  always_comb begin
    lut_idx[0] = f_in;
    lut_idx[1] = g_in;
    if (md.carry_en) begin
      lut_idx[0][CARRY_POS] = cin;
      lut_idx[1][CARRY_POS] = c_mid;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_tab
    lcell_table #(.K(LUT_K)) u_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && (md.tbl_sel == 1'(i))),
      .wr_addr (cfg_addr),
      .wr_bit  (cfg_din),
      .rd_idx  (lut_idx[i]),
      .rd_bit  (lut_q[i]),
      .tab_o   (tab_arr[i])
    );
  end

  assign tab_f = tab_arr[0];
  assign tab_g = tab_arr[1];

  assign h_idx = {h_in, lut_q[1], lut_q[0]};
  assign h_q   = md.h_tab[h_idx];

  assign x_o = md.x_sel ? h_q : lut_q[0];
  assign y_o = md.y_sel ? h_q : lut_q[1];

  logic [1:0] comb_v, srv_v, byp_v, reg_v;
  logic       ce_ok;
  assign comb_v = {y_o, x_o};
  assign srv_v  = {md.srv_y, md.srv_x};
  assign byp_v  = {md.y_byp, md.x_byp};
  assign ce_ok  = !md.ce_use || ec;

  for (genvar j = 0; j < 2; j++) begin : g_store
    lcell_store u_st (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (comb_v[j]),
      .ce     (ce_ok),
      .sr     (sr),
      .sr_val (srv_v[j]),
      .byp    (byp_v[j]),
      .q_o    (reg_v[j])
    );
  end

  assign xq_o = reg_v[0];
  assign yq_o = reg_v[1];
endmodule

// File: rtl/lcell_checker.sv
module lcell_checker
  import lcell_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] cfg_mode,
  input logic              cfg_we,
  input logic [LUT_K-1:0]  cfg_addr,
  input logic              cfg_din,
  input logic              ec,
  input logic              sr,
  input logic              x_o,
  input logic              y_o,
  input logic              xq_o,
  input logic              yq_o,
  input logic [LUT_D-1:0]  f_tab,
  input logic [LUT_D-1:0]  g_tab
);
  lcell_mode_t md;
  assign md = lcell_mode_t'(cfg_mode);

  p_f_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_we) && !$past(md.tbl_sel)) |-> f_tab[$past(cfg_addr)] == $past(cfg_din));

  p_g_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_we) && $past(md.tbl_sel)) |-> g_tab[$past(cfg_addr)] == $past(cfg_din));

  p_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cfg_we)) |-> (f_tab == $past(f_tab)) && (g_tab == $past(g_tab)));

  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!sr && (!md.ce_use || ec)) && !md.x_byp && !$past(md.x_byp))
      |-> xq_o == $past(x_o));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!sr && md.ce_use && !ec) && !md.y_byp && !$past(md.y_byp))
      |-> yq_o == $past(yq_o));

  p_sr_x_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sr) && !md.x_byp) |-> xq_o == $past(md.srv_x));

  p_sr_y_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sr) && !md.y_byp) |-> yq_o == $past(md.srv_y));

  p_byp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (md.x_byp |-> xq_o == x_o) and (md.y_byp |-> yq_o == y_o));
endmodule

bind lut_logic_cell lcell_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_mode (cfg_mode),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .cfg_din  (cfg_din),
  .ec       (ec),
  .sr       (sr),
  .x_o      (x_o),
  .y_o      (y_o),
  .xq_o     (xq_o),
  .yq_o     (yq_o),
  .f_tab    (tab_f),
  .g_tab    (tab_g)
);

// File: tb/sim_lut_logic_cell.sv
module sim_lut_logic_cell;
  import lcell_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [MODE_W-1:0] cfg_mode;
  logic              cfg_we, cfg_din, h_in, cin, ec, sr;
  logic [LUT_K-1:0]  cfg_addr, f_in, g_in;
  logic              x_o, y_o, xq_o, yq_o, cout;

  lut_logic_cell u0 (.*);

  typedef struct {
    string      req;
    logic [4:0] exp;
  } item_t;

  item_t       sb[$];
  int          n_chk = 0;
  int          n_fail = 0;
  lcell_mode_t m;
  logic [15:0] mf, mg;
  logic        mxq, myq;

  // Expected {cout, y, x} from the requirement text (R2-R5)
  function automatic logic [2:0] model(input logic [15:0] tf, input logic [15:0] tg,
                                       input logic [3:0] f, input logic [3:0] g,
                                       input logic h, input logic ci);
    logic [3:0] fi, gi;
    logic c0, co, fo, go, ho;
    c0 = maj3(f[0], f[1], ci);
    fi = f;
    gi = g;
    co = 1'b0;
    if (m.carry_en) begin
      fi[2] = ci;
      gi[2] = c0;
      co    = maj3(g[0], g[1], c0);
    end
    fo = tf[fi];
    go = tg[gi];
    ho = m.h_tab[{h, go, fo}];
    return {co, m.y_sel ? ho : go, m.x_sel ? ho : fo};
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {cout,yq,xq,y,x} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Driver: one stimulus per cycle, pushes the value expected just after the edge
  task automatic step(input string req, input logic we, input logic [3:0] a, input logic d,
                      input logic [3:0] f, input logic [3:0] g, input logic h,
                      input logic ci, input logic e, input logic s);
    logic [2:0] pre, post;
    item_t it;
    @(negedge clk);
    cfg_mode = m; cfg_we = we; cfg_addr = a; cfg_din = d;
    f_in = f; g_in = g; h_in = h; cin = ci; ec = e; sr = s;
    pre = model(mf, mg, f, g, h, ci);
    if (s) begin
      mxq = m.srv_x;
      myq = m.srv_y;
    end else if (!m.ce_use || e) begin
      mxq = pre[0];
      myq = pre[1];
    end
    if (we) begin
      if (m.tbl_sel) mg[a] = d;
      else           mf[a] = d;
    end
    post   = model(mf, mg, f, g, h, ci);
    it.req = req;
    it.exp = {post[2], m.y_byp ? post[1] : myq, m.x_byp ? post[0] : mxq, post[1], post[0]};
    sb.push_back(it);
  endtask

  // Monitor: compares after every rising edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.req, {cout, yq_o, xq_o, y_o, x_o}, it.exp);
      end
    end
  end

  task automatic load_tab(input string req, input logic sel, input logic [15:0] val);
    m.tbl_sel = sel;
    for (int a = 0; a < 16; a++)
      step(req, 1'b1, 4'(a), val[a], 4'(a), 4'(15 - a), 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic drain();
    repeat (2) @(posedge clk);
    #4;
  endtask

  bit finished = 0;

  initial begin
    m = '0; mf = '0; mg = '0; mxq = 0; myq = 0;
    rst_n = 0; cfg_mode = '0; cfg_we = 0; cfg_addr = '0; cfg_din = 0;
    f_in = '0; g_in = '0; h_in = 0; cin = 0; ec = 0; sr = 0;
    @(posedge clk); #3;
    check("R9 reset state", {cout, yq_o, xq_o, y_o, x_o}, 5'b0);
    @(negedge clk); rst_n = 1;

    // R1 / R2: load both tables, then sweep each
    load_tab("R1 load F", 1'b0, 16'hA5C3);
    load_tab("R1 load G", 1'b1, 16'h3C5A);
    for (int i = 0; i < 16; i++)
      step("R2 sweep", 1'b0, 4'd0, 1'b0, 4'(i), 4'((i * 7) & 15), 1'b0, 1'b0, 1'b1, 1'b0);

    // R1: writes to G leave F intact
    m.tbl_sel = 1'b1;
    step("R1 write G only", 1'b1, 4'd3, 1'b1, 4'd3, 4'd3, 1'b0, 1'b0, 1'b1, 1'b0);
    step("R1 F unchanged", 1'b0, 4'd0, 1'b0, 4'd3, 4'd3, 1'b0, 1'b0, 1'b1, 1'b0);

    // R3 / R4: route through H
    m.h_tab = 8'b1001_0110;
    m.x_sel = 1'b1;
    for (int i = 0; i < 16; i++)
      step("R3 R4 H path", 1'b0, 4'd0, 1'b0, 4'(i), 4'(15 - i), i[0], 1'b0, 1'b1, 1'b0);
    m.x_sel = 1'b0;
    m.y_sel = 1'b1;
    for (int i = 0; i < 8; i++)
      step("R4 Y select", 1'b0, 4'd0, 1'b0, 4'(i * 2), 4'(i), i[1], 1'b0, 1'b1, 1'b0);
    m.y_sel = 1'b0;

    // R6: clock enable use
    m.ce_use = 1'b1;
    for (int i = 0; i < 12; i++)
      step("R6 ce", 1'b0, 4'd0, 1'b0, 4'(i), 4'(i + 3), 1'b0, 1'b0, i[1], 1'b0);

    // R7: set/reset beats a low enable
    m.srv_x = 1'b1; m.srv_y = 1'b0;
    step("R7 sr over ec", 1'b0, 4'd0, 1'b0, 4'd1, 4'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R7 hold after sr", 1'b0, 4'd0, 1'b0, 4'd6, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    m.srv_x = 1'b0; m.srv_y = 1'b1;
    step("R7 sr swapped", 1'b0, 4'd0, 1'b0, 4'd6, 4'd2, 1'b0, 1'b0, 1'b1, 1'b1);
    m.ce_use = 1'b0;

    // R8: bypass
    m.x_byp = 1'b1; m.y_byp = 1'b1;
    for (int i = 0; i < 6; i++)
      step("R8 bypass", 1'b0, 4'd0, 1'b0, 4'(i * 3), 4'(i * 5), 1'b0, 1'b0, 1'b1, 1'b0);
    m.x_byp = 1'b0; m.y_byp = 1'b0;

    // R10: write the entry that the X flop is capturing through
    m.tbl_sel = 1'b0;
    step("R10 collide", 1'b1, 4'd5, ~mf[5], 4'd5, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    step("R10 after", 1'b0, 4'd0, 1'b0, 4'd5, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    step("R10 collide again", 1'b1, 4'd9, ~mf[9], 4'd9, 4'd1, 1'b0, 1'b0, 1'b1, 1'b0);

    // R5: carry chain with sum tables
    load_tab("R1 load F sum", 1'b0, 16'h9696);
    load_tab("R1 load G sum", 1'b1, 16'h9696);
    m.carry_en = 1'b1;
    for (int i = 0; i < 32; i++)
      step("R5 carry", 1'b0, 4'd0, 1'b0, {2'b10, i[1:0]}, {2'b01, i[3:2]}, 1'b0, i[4], 1'b1, 1'b0);
    m.carry_en = 1'b0;
    step("R5 carry off", 1'b0, 4'd0, 1'b0, 4'd3, 4'd3, 1'b0, 1'b1, 1'b1, 1'b0);

    // R9: reset mid-run clears tables and flops
    drain();
    m = '0;
    @(negedge clk);
    cfg_mode = m; f_in = 4'd3; g_in = 4'd3; cin = 0; ec = 1; sr = 0; cfg_we = 0;
    rst_n = 0;
    #2;
    check("R9 mid-run reset", {cout, yq_o, xq_o, y_o, x_o}, 5'b0);
    mf = '0; mg = '0; mxq = 0; myq = 0;
    @(negedge clk); rst_n = 1;
    step("R9 tables clear", 1'b0, 4'd0, 1'b0, 4'd1, 4'd6, 1'b0, 1'b0, 1'b1, 1'b0);
    drain();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule